// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host port and an external asynchronous static RAM of 128K words by 8 bits. The host raises a one-cycle request with a direction bit, an address and, for writes, a data byte. The block then runs the memory strobes through a fixed series of phases and pulses `host_done` once when the access is complete. For a read, the byte sampled from the memory bus is on `host_rdata` in that same cycle.

Each phase lasts a whole number of clock cycles. These counts are worked out when the block is built, from the clock period and the memory's minimum times. A write is ended by raising the write strobe while both chip selects, the address and the driven data stay valid for one more cycle. The output enable stays high for the whole write, so the memory and the block never drive the shared data bus at the same time. The bidirectional bus is split into an output value, an output enable and an input value; the pad is expected to sit outside this block.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, with no access running, the pins rest at `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dout_oe`=0, and `host_done` is 0.
- R2: A write asserts both selects (`mem_cs1_n`=0, `mem_cs2`=1) with the address for SU cycles. It then holds `mem_we_n` low for exactly WP consecutive cycles. `mem_oe_n` stays 1 in every cycle of the write.
- R3: After a write's low pulse, one cycle follows with `mem_we_n`=1 while the selects, the address and the driven data are all still held. `host_done` is 1 in that cycle only, which is cycle SU+WP+1 after the request edge. In the next cycle the selects and `mem_dout_oe` are released.
- R4: While `mem_we_n` is low, `mem_dout_oe`=1 and `mem_dout` equals the write byte that was accepted with the request.
- R5: A read holds both selects, `mem_we_n`=1, `mem_oe_n`=0 and `mem_dout_oe`=0 for RD cycles. The block never drives the bus while `mem_oe_n` is 0.
- R6: A read registers `mem_din` at the end of its last access cycle. In the following cycle, RD+1 after the request edge, `host_done` is 1, `mem_oe_n` is 1, and `host_rdata` holds the sampled byte until the next read.
- R7: `mem_addr` does not change while the selects stay asserted over consecutive cycles.
- R8: A request raised while an access is in progress is ignored. It changes neither memory contents nor the timing of the access that is running.
- R9: A request is accepted only in an idle cycle. A request held high through the `host_done` cycle is taken one cycle later, and the next access's strobes start in the cycle after that.
- R10: The counts are WP = max(ceil(tWP/T), ceil(tDW/T)), SU = max(ceil(tAW/T) − WP, 0) and RD = ceil(tAA/T) + 1, where T is the clock period. With a 10 ns clock and 55/65/30/70 ns limits these give WP=6, SU=1 and RD=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, sampled only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Last byte read |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Byte to drive onto the memory bus |
| mem_dout_oe | output | 1 | Enable for the bus driver |
| mem_din | input | DATA_W | Byte seen on the memory bus |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
Two functions can fall in the same cycle: the completion pulse of one access and the acceptance window for the next request. The bench raises `host_req` in the very cycle where it sees `host_done` and keeps it raised. The pulse cycle must not start a new access. The following idle cycle must show resting pins, and the access strobes must appear exactly one cycle after that. A second overlap comes from raising a request in the middle of a write or a read. Its effect is judged by reading back the targeted address and by the unchanged latency of the access that was already running.

// File: rtl/sram_ctl_pkg.sv
// Package: shared phase type and compile-time arithmetic helpers for the
// SRAM strobe sequencer. Assumes all times are given in picoseconds.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACC   = 3'd4,
        PH_RDONE  = 3'd5
    } phase_e;

    // Ceiling division for positive operands.
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_wait.sv
// Module: phase wait counter. It loads a count when a phase begins, then
// counts down to zero and holds there. expired is high while the count
// is zero. Assumes load values fit in CW bits.
module sram_ctl_wait #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Down-counter: reload on phase entry, otherwise step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
// Module: access phase sequencer. Accepts a request only in idle and walks
// the write or read phases, reloading the wait counter on entry to every
// timed phase. Assumes WP_CYC>=1 and RD_CYC>=1; SU_CYC may be zero.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int SU_CYC = 1,
    parameter int WP_CYC = 6,
    parameter int RD_CYC = 8,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic          expired,
    output phase_e        phase,
    output logic          accept,
    output logic          load,
    output logic [CW-1:0] load_val
);

    localparam logic [CW-1:0] SU_LD = (SU_CYC > 0) ? CW'(SU_CYC - 1) : '0;
    localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);

    phase_e phase_nx;

    assign accept = (phase == PH_IDLE) && req;

    // Next-phase and counter-load decision.
    always_comb begin
        phase_nx = phase;
        load     = 1'b0;
        load_val = '0;
        unique case (phase)
            PH_IDLE: begin
                if (req) begin
                    load = 1'b1;
                    if (!we) begin
                        phase_nx = PH_RACC;
                        load_val = RD_LD;
                    end else if (SU_CYC > 0) begin
                        phase_nx = PH_WSETUP;
                        load_val = SU_LD;
                    end else begin
                        phase_nx = PH_WPULSE;
                        load_val = WP_LD;
                    end
                end
            end
            PH_WSETUP: begin
                if (expired) begin
                    phase_nx = PH_WPULSE;
                    load     = 1'b1;
                    load_val = WP_LD;
                end
            end
            PH_WPULSE: if (expired) phase_nx = PH_WHOLD;
            PH_WHOLD:  phase_nx = PH_IDLE;
            PH_RACC:   if (expired) phase_nx = PH_RDONE;
            PH_RDONE:  phase_nx = PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else
            phase <= phase_nx;
    end

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WHOLD || phase == PH_RDONE) |=> (phase == PH_IDLE)); // R9

endmodule

// File: rtl/sram_ctl_pins.sv
// Module: pin decoder and read capture. Maps the current phase onto the
// memory strobes and the host completion pulse, and registers the memory
// bus at the end of the read access window. Assumes addr/data are held
// stable by the caller for the whole access.
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              expired,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_oe,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    logic selected;

    // Strobe decode from the phase.
    always_comb begin
        selected    = (phase != PH_IDLE);
        mem_cs1_n   = !selected;
        mem_cs2     = selected;
        mem_we_n    = (phase != PH_WPULSE);
        mem_oe_n    = (phase != PH_RACC);
        mem_dout_oe = (phase == PH_WPULSE) || (phase == PH_WHOLD);
        done        = (phase == PH_WHOLD) || (phase == PH_RDONE);
        mem_addr    = addr_q;
        mem_dout    = wdata_q;
    end

    // Read capture on the last access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (phase == PH_RACC && expired)
            rdata <= mem_din;
    end

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_oe |-> mem_oe_n); // R5

endmodule

// File: rtl/sram_ctl.sv
// Module: top of the asynchronous SRAM strobe sequencer. Derives the phase
// cycle counts from the clock period and memory minimum times, latches the
// host request on acceptance, and wires the sequencer, wait counter and
// pin decoder. Assumes a single-cycle host request and an external pad.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 10000,
    parameter int T_WP_PS = 55000,
    parameter int T_AW_PS = 65000,
    parameter int T_DW_PS = 30000,
    parameter int T_AA_PS = 70000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_oe,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n
);

    localparam int WP_CYC = imax(cdiv(T_WP_PS, CLK_PS), cdiv(T_DW_PS, CLK_PS));
    localparam int SU_CYC = imax(cdiv(T_AW_PS, CLK_PS) - WP_CYC, 0);
    localparam int RD_CYC = cdiv(T_AA_PS, CLK_PS) + 1;
    localparam int CW     = $clog2(imax(imax(SU_CYC, WP_CYC), RD_CYC) + 1);

    phase_e            phase;
    logic              accept;
    logic              load;
    logic [CW-1:0]     load_val;
    logic              expired;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Hold the accepted address and write byte for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    sram_ctl_seq #(
        .SU_CYC (SU_CYC),
        .WP_CYC (WP_CYC),
        .RD_CYC (RD_CYC),
        .CW     (CW)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (host_req),
        .we       (host_we),
        .expired  (expired),
        .phase    (phase),
        .accept   (accept),
        .load     (load),
        .load_val (load_val)
    );

    sram_ctl_wait #(
        .CW (CW)
    ) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_ctl_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .expired     (expired),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .mem_din     (mem_din),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_oe (mem_dout_oe),
        .mem_cs1_n   (mem_cs1_n),
        .mem_cs2     (mem_cs2),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .done        (host_done),
        .rdata       (host_rdata)
    );

    // Length of the current write-strobe low run, for pulse-width checking.
    logic [7:0] wl_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            wl_run <= '0;
        else if (!mem_we_n)
            wl_run <= wl_run + 1'b1;
        else
            wl_run <= '0;
    end

    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R2
    AST_W_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wl_run == 8'(WP_CYC))); // R2
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_dout_oe)); // R4
    AST_W_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs1_n && mem_cs2 && mem_dout_oe
                             && $stable(mem_addr) && $stable(mem_dout))); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done); // R3

endmodule

// File: tb/test_sram_ctl.sv
// Bench: sweeps every word of a 64-word configuration with two data
// patterns, checking strobe timing, latencies and read-back, plus
// mid-access requests and a request colliding with the done cycle.
module test_sram_ctl;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NW = 1 << AW;
    // Counts worked out from the timing limits, independently of the RTL.
    localparam int T   = 10000;
    localparam int XWP = ((55000 + T - 1) / T > (30000 + T - 1) / T) ?
                         (55000 + T - 1) / T : (30000 + T - 1) / T;
    localparam int XSU = ((65000 + T - 1) / T > XWP) ? (65000 + T - 1) / T - XWP : 0;
    localparam int XRD = (70000 + T - 1) / T + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_oe;
    logic [DW-1:0] mem_din;
    logic          mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] expv [NW];

    always #2 clk = ~clk;

    sram_ctl #(.ADDR_W(AW), .DATA_W(DW)) i_sram_ctl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_oe(mem_dout_oe), .mem_din(mem_din), .mem_cs1_n(mem_cs1_n),
        .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // Memory model: stores on the rising write strobe while selected.
    always @(posedge mem_we_n)
        if (mem_cs1_n === 1'b0 && mem_cs2 === 1'b1 && mem_dout_oe === 1'b1)
            mem[mem_addr] = mem_dout;

    assign mem_din = (!mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n) ? mem[mem_addr] : 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(mem_cs1_n === 1'b1 && mem_cs2 === 1'b0 && mem_we_n === 1'b1 &&
            mem_oe_n === 1'b1 && mem_dout_oe === 1'b0 && host_done === 1'b0,
            tag, {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dout_oe, host_done}, 6'b101100);
    endtask

    // Write with optional mid-access request aimed at inj_a.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit inj, input logic [AW-1:0] inj_a);
        int cyc = 0, wl = 0, su = 0;
        bit seen_w = 0, oe_bad = 0, d_bad = 0, a_bad = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        while (1) begin
            cyc++;
            if (mem_addr !== a) a_bad = 1;
            if (!mem_we_n) begin
                wl++; seen_w = 1;
                if (!mem_oe_n) oe_bad = 1;
                if (!mem_dout_oe || mem_dout !== d) d_bad = 1;
            end else if (!seen_w && !mem_cs1_n && mem_cs2) su++;
            if (host_done || cyc > 40) break;
            if (inj && cyc == 2) begin
                host_req = 1'b1; host_we = 1'b1; host_addr = inj_a; host_wdata = ~d;
            end else host_req = 1'b0;
            @(negedge clk);
        end
        host_req = 1'b0;
        chk(cyc == XSU + XWP + 1, "R3 write latency", cyc, XSU + XWP + 1);
        chk(wl == XWP, "R2/R10 W low cycles", wl, XWP);
        chk(su == XSU, "R2/R10 setup cycles", su, XSU);
        chk(!oe_bad, "R2 OE high in write", oe_bad, 0);
        chk(!d_bad, "R4 data driven under W", d_bad, 0);
        chk(!a_bad, "R7 address stable", a_bad, 0);
        chk(mem_we_n === 1'b1 && !mem_cs1_n && mem_cs2 && mem_dout_oe,
            "R3 hold cycle pins", {mem_we_n, mem_cs1_n, mem_cs2, mem_dout_oe}, 4'b1011);
        @(negedge clk);
        chk_idle("R3 release after write");
    endtask

    // Read with optional mid-access write request aimed at inj_a.
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e,
                           input bit inj, input logic [AW-1:0] inj_a);
        int cyc = 0, acc = 0;
        bit bad = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        while (1) begin
            cyc++;
            if (!host_done) begin
                acc++;
                if (mem_oe_n || !mem_we_n || mem_dout_oe || mem_cs1_n || !mem_cs2) bad = 1;
            end
            if (host_done || cyc > 40) break;
            if (inj && cyc == 3) begin
                host_req = 1'b1; host_we = 1'b1; host_addr = inj_a; host_wdata = 8'h3C;
            end else host_req = 1'b0;
            @(negedge clk);
        end
        host_req = 1'b0;
        chk(cyc == XRD + 1, "R6 read latency", cyc, XRD + 1);
        chk(acc == XRD && !bad, "R5/R10 access window", acc, XRD);
        chk(host_rdata === e, "R6 read data", host_rdata, e);
        chk(mem_oe_n === 1'b1, "R6 OE high at done", mem_oe_n, 1);
        @(negedge clk);
        chk_idle("R1 idle after read");
        chk(host_rdata === e, "R6 read data held", host_rdata, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk_idle("R1 pins in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 pins after reset");

        // First pattern: write every word, then read every word.
        for (int a = 0; a < NW; a++) begin
            expv[a] = 8'(a * 37 + 91);
            do_write(AW'(a), expv[a], 1'b0, '0);
        end
        for (int a = 0; a < NW; a++) do_read(AW'(a), expv[a], 1'b0, '0);

        // Requests during a running write and a running read are ignored.
        expv[5] = 8'hA5;
        do_write(AW'(5), 8'hA5, 1'b1, AW'(9));
        do_read(AW'(9), expv[9], 1'b0, '0);
        chk(mem[9] === expv[9], "R8 word untouched after write", mem[9], expv[9]);
        do_read(AW'(10), expv[10], 1'b1, AW'(11));
        do_read(AW'(11), expv[11], 1'b0, '0);
        do_read(AW'(5), 8'hA5, 1'b0, '0);

        // Request raised in the done cycle and held.
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = AW'(20); host_wdata = 8'h5A;
        expv[20] = 8'h5A;
        while (!host_done) @(negedge clk);
        host_we = 1'b0; host_addr = AW'(20);
        @(negedge clk);
        chk_idle("R9 idle cycle after done");
        @(negedge clk);
        chk(mem_oe_n === 1'b0 && mem_cs1_n === 1'b0, "R9 read starts next cycle",
            {mem_oe_n, mem_cs1_n}, 0);
        host_req = 1'b0;
        repeat (XRD) @(negedge clk);
        chk(host_done === 1'b1 && host_rdata === 8'h5A, "R9 back-to-back read data",
            host_rdata, 8'h5A);
        @(negedge clk);

        // Second pattern: inverted values, reverse address order.
        for (int a = NW - 1; a >= 0; a--) begin
            expv[a] = ~8'(a * 53 + 17);
            do_write(AW'(a), expv[a], 1'b0, '0);
        end
        for (int a = 0; a < NW; a++) do_read(AW'(a), expv[a], 1'b0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule